// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, one frame at a time, whether a received Ethernet frame is taken in, and labels accepted frames as broadcast or multicast. The receive path presents a single-cycle request holding the 48-bit destination address, the frame length counted without the FCS, and a four-bit mode word. Exactly one cycle later the block returns one response cycle carrying an accept bit and two class bits.

The decision walks a fixed chain of tests. The first test that applies settles the outcome and the later tests are skipped. The chain is: the short-frame test, then promiscuous acceptance of individual addresses, then acceptance of all group addresses, then broadcast, and finally a lookup in a 16-entry table of station addresses. Table entries are written through a direct write port. A 16-bit enable mask, written through its own port, selects which entries take part in the lookup. While the controller is in reset, software can read any entry back 16 bits at a time.

Address byte k, where byte 0 is the first byte on the wire, sits in bits [8k+7:8k] of every 48-bit address in this block. Bit 0 of byte 0 is the individual/group bit.

Top module: `rx_addr_filter`

## Requirements
- R1: Each cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the following cycle. `rsp_accept`, `rsp_bcast` and `rsp_mcast` are low whenever `rsp_valid` is low.
- R2: A frame with `req_len` below 60 is a short frame. It is accepted with no class bits when `req_mode[3]` (short-frame accept) is set and rejected otherwise, whatever the other mode bits and the table hold.
- R3: When `req_mode[1]` (promiscuous) is set, a frame of 60 bytes or more with `req_dst[0]` clear is accepted with no class bits. Promiscuous mode alone does not accept a group address.
- R4: When `req_mode[0]` (all-group) is set, a frame of 60 bytes or more with `req_dst[0]` set is accepted with `rsp_mcast` high. This test ranks above the broadcast test, so an all-ones address under both modes is flagged multicast only.
- R5: When `req_mode[2]` (broadcast) is set and no earlier test applied, an all-ones destination is accepted with `rsp_bcast` high.
- R6: If no earlier test applied, the frame is accepted with no class bits only when its destination equals all 48 bits of a table entry whose enable-mask bit is set. Otherwise it is rejected.
- R7: After reset the enable mask is zero, so no table entry matches until a mask is written. After reset all table entries read as zero.
- R8: A write with `cam_wr_en` stores `cam_wr_addr` into entry `cam_wr_idx`. A write with `mask_wr_en` replaces the enable mask. Either write takes effect for requests from the next cycle on.
- R9: `rd_data` returns 16-bit words of entry `rd_ptr`, low byte first: `rd_word` 0 gives {byte1,byte0}, 1 gives {byte3,byte2}, 2 gives {byte5,byte4}, and 3 gives zero. This holds only while `in_reset` is high; otherwise `rd_data` is zero.
- R10: `rsp_bcast` and `rsp_mcast` are never high together, and neither is high without `rsp_accept`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_reset | input | 1 | Controller is in its reset state; enables table readback |
| cam_wr_en | input | 1 | Write one table entry |
| cam_wr_idx | input | 4 | Entry index for the write |
| cam_wr_addr | input | 48 | Station address to store |
| mask_wr_en | input | 1 | Replace the enable mask |
| mask_wr_data | input | 16 | New enable mask, bit i for entry i |
| rd_ptr | input | 4 | Entry selected for readback |
| rd_word | input | 2 | 16-bit word selected for readback |
| rd_data | output | 16 | Readback word |
| req_valid | input | 1 | Filter request strobe |
| req_dst | input | 48 | Destination address of the frame |
| req_len | input | 16 | Frame length in bytes without FCS |
| req_mode | input | 4 | Mode: [3] short accept, [2] broadcast, [1] promiscuous, [0] all-group |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_accept | output | 1 | Frame is accepted |
| rsp_bcast | output | 1 | Accepted as broadcast |
| rsp_mcast | output | 1 | Accepted as multicast |

## Verification
The assertions check, on every cycle, the request-to-response timing and the single response per request. They also check that a short frame is never accepted without its mode bit and never carries a class bit, that the class bits are exclusive and tied to accept and to the address that caused them, and that readback stays silent outside reset. Only the bench scenarios can show the order of the decision chain. That covers the short-frame test overruling a table hit, multicast outranking broadcast, and the exact 60-byte boundary. The bench also shows that the table lookup honours the enable mask from reset onward and that stored entries come back in low-byte-first word order.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    // Mode word bit positions
    localparam int MODE_W     = 4;
    localparam int MODE_ALLMC = 0;
    localparam int MODE_PROM  = 1;
    localparam int MODE_BCAST = 2;
    localparam int MODE_RUNT  = 3;

    typedef struct packed {
        logic valid;
        logic accept;
        logic bcast;
        logic mcast;
    } rsp_t;
endpackage

// File: rtl/rxf_cam_store.sv
module rxf_cam_store #(
    parameter int N_ENT  = 16,
    parameter int ADDR_W = 48,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              mask_en,
    input  logic [N_ENT-1:0]  mask_data,
    input  logic              rd_allow,
    input  logic [IDX_W-1:0]  rd_ptr,
    input  logic [1:0]        rd_word,
    output logic [15:0]       rd_data,
    output logic [ADDR_W-1:0] ent_o [N_ENT],
    output logic [N_ENT-1:0]  en_o
);
    localparam int SLOT_W = 64; // four 16-bit readback slots

    logic [ADDR_W-1:0] ent_d [N_ENT];
    logic [ADDR_W-1:0] ent_q [N_ENT];
    logic [N_ENT-1:0]  en_d, en_q;
    logic [SLOT_W-1:0] slots;

    always_comb begin
        ent_d = ent_q;
        en_d  = en_q;
        if (wr_en)   ent_d[wr_idx] = wr_addr;   // R8
        if (mask_en) en_d = mask_data;          // R8
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
            en_q <= '0;                         // R7
        end else begin
            ent_q <= ent_d;
            en_q  <= en_d;
        end
    end

    // R9: low-byte-first words, unused slot reads zero, silent outside reset
    assign slots   = {{(SLOT_W-ADDR_W){1'b0}}, ent_q[rd_ptr]};
    assign rd_data = rd_allow ? slots[{rd_word, 4'b0000} +: 16] : 16'h0000;

    assign ent_o = ent_q;
    assign en_o  = en_q;
endmodule

// File: rtl/rxf_cam_match.sv
module rxf_cam_match #(
    parameter int N_ENT  = 16,
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] ent [N_ENT],
    input  logic [N_ENT-1:0]  en,
    input  logic [ADDR_W-1:0] key,
    output logic              hit
);
    logic [N_ENT-1:0] eq;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign eq[g] = (ent[g] == key);
    end

    assign hit = |(eq & en);                    // R6
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int N_ENT   = 16,
    parameter int ADDR_W  = 48,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 60,
    localparam int IDX_W  = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_reset,
    input  logic              cam_wr_en,
    input  logic [IDX_W-1:0]  cam_wr_idx,
    input  logic [ADDR_W-1:0] cam_wr_addr,
    input  logic              mask_wr_en,
    input  logic [N_ENT-1:0]  mask_wr_data,
    input  logic [IDX_W-1:0]  rd_ptr,
    input  logic [1:0]        rd_word,
    output logic [15:0]       rd_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_dst,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [MODE_W-1:0] req_mode,
    output logic              rsp_valid,
    output logic              rsp_accept,
    output logic              rsp_bcast,
    output logic              rsp_mcast
);
    logic [ADDR_W-1:0] ent [N_ENT];
    logic [N_ENT-1:0]  en;
    logic              cam_hit;
    rsp_t              rsp_d, rsp_q;

    rxf_cam_store #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cam_wr_en),
        .wr_idx    (cam_wr_idx),
        .wr_addr   (cam_wr_addr),
        .mask_en   (mask_wr_en),
        .mask_data (mask_wr_data),
        .rd_allow  (in_reset),
        .rd_ptr    (rd_ptr),
        .rd_word   (rd_word),
        .rd_data   (rd_data),
        .ent_o     (ent),
        .en_o      (en)
    );

    rxf_cam_match #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_match (
        .ent (ent),
        .en  (en),
        .key (req_dst),
        .hit (cam_hit)
    );

    // Decision chain: first applicable test wins
    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;                                   // R1
            if (req_len < LEN_W'(MIN_LEN)) begin
                rsp_d.accept = req_mode[MODE_RUNT];               // R2
            end else if (req_mode[MODE_PROM] && !req_dst[0]) begin
                rsp_d.accept = 1'b1;                              // R3
            end else if (req_mode[MODE_ALLMC] && req_dst[0]) begin
                rsp_d.accept = 1'b1;                              // R4
                rsp_d.mcast  = 1'b1;
            end else if (req_mode[MODE_BCAST] && (&req_dst)) begin
                rsp_d.accept = 1'b1;                              // R5
                rsp_d.bcast  = 1'b1;
            end else begin
                rsp_d.accept = cam_hit;                           // R6
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_accept = rsp_q.accept;
    assign rsp_bcast  = rsp_q.bcast;
    assign rsp_mcast  = rsp_q.mcast;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int ADDR_W  = 48,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 60
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_reset,
    input logic [15:0]       rd_data,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_dst,
    input logic [LEN_W-1:0]  req_len,
    input logic [3:0]        req_mode,
    input logic              rsp_valid,
    input logic              rsp_accept,
    input logic              rsp_bcast,
    input logic              rsp_mcast
);
    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_accept || rsp_bcast || rsp_mcast));
    assert_short_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_len < LEN_W'(MIN_LEN) && !req_mode[3]) |=> !rsp_accept);
    assert_short_noclass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_len < LEN_W'(MIN_LEN)) |=> !(rsp_bcast || rsp_mcast));
    assert_mcast_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_dst[0]) |=> !rsp_mcast);
    assert_bcast_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(&req_dst)) |=> !rsp_bcast);
    assert_class_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_bcast && rsp_mcast));
    assert_class_needs_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_bcast || rsp_mcast) |-> rsp_accept);
    assert_readback_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_reset |-> rd_data == 16'h0000);
endmodule

bind rx_addr_filter rxf_checker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)
) u_rxf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_reset   (in_reset),
    .rd_data    (rd_data),
    .req_valid  (req_valid),
    .req_dst    (req_dst),
    .req_len    (req_len),
    .req_mode   (req_mode),
    .rsp_valid  (rsp_valid),
    .rsp_accept (rsp_accept),
    .rsp_bcast  (rsp_bcast),
    .rsp_mcast  (rsp_mcast)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
    localparam logic [47:0] STA_A = 48'h6655_4433_2210; // unicast, entry 3
    localparam logic [47:0] STA_B = 48'h0C0B_0A09_0804; // unicast, entry 5
    localparam logic [47:0] STA_U = 48'h5A5A_5A5A_5A02; // unicast, not stored
    localparam logic [47:0] GRP   = 48'h0000_5E00_0001; // group address
    localparam logic [47:0] ALL1  = 48'hFFFF_FFFF_FFFF;

    typedef struct packed {
        logic [3:0]  mode;
        logic [15:0] len;
        logic [47:0] dst;
        logic [2:0]  exp;   // {accept, bcast, mcast}
        logic [3:0]  req;   // requirement number for the message
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 16'd64, STA_A, 3'b100, 4'd6},
        '{4'b0000, 16'd64, STA_B, 3'b000, 4'd6},
        '{4'b0000, 16'd59, STA_A, 3'b000, 4'd2},
        '{4'b1000, 16'd59, STA_U, 3'b100, 4'd2},
        '{4'b1100, 16'd59, ALL1,  3'b100, 4'd2},
        '{4'b0010, 16'd60, STA_U, 3'b100, 4'd3},
        '{4'b0010, 16'd64, GRP,   3'b000, 4'd3},
        '{4'b0010, 16'd59, STA_U, 3'b000, 4'd2},
        '{4'b0001, 16'd64, GRP,   3'b101, 4'd4},
        '{4'b0101, 16'd64, ALL1,  3'b101, 4'd4},
        '{4'b0100, 16'd64, ALL1,  3'b110, 4'd5},
        '{4'b0100, 16'd64, GRP,   3'b000, 4'd5},
        '{4'b0000, 16'd64, ALL1,  3'b000, 4'd5},
        '{4'b0001, 16'd64, STA_A, 3'b100, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_reset = 1'b0;
    logic        cam_wr_en = 1'b0;
    logic [3:0]  cam_wr_idx = '0;
    logic [47:0] cam_wr_addr = '0;
    logic        mask_wr_en = 1'b0;
    logic [15:0] mask_wr_data = '0;
    logic [3:0]  rd_ptr = '0;
    logic [1:0]  rd_word = '0;
    logic [15:0] rd_data;
    logic        req_valid = 1'b0;
    logic [47:0] req_dst = '0;
    logic [15:0] req_len = '0;
    logic [3:0]  req_mode = '0;
    logic        rsp_valid, rsp_accept, rsp_bcast, rsp_mcast;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rx_addr_filter dut (
        .clk(clk), .rst_n(rst_n), .in_reset(in_reset),
        .cam_wr_en(cam_wr_en), .cam_wr_idx(cam_wr_idx), .cam_wr_addr(cam_wr_addr),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .rd_ptr(rd_ptr), .rd_word(rd_word), .rd_data(rd_data),
        .req_valid(req_valid), .req_dst(req_dst), .req_len(req_len), .req_mode(req_mode),
        .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
        .rsp_bcast(rsp_bcast), .rsp_mcast(rsp_mcast)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_entry(input logic [3:0] idx, input logic [47:0] a);
        @(negedge clk);
        cam_wr_en = 1'b1; cam_wr_idx = idx; cam_wr_addr = a;
        @(negedge clk);
        cam_wr_en = 1'b0;
    endtask

    task automatic write_mask(input logic [15:0] m);
        @(negedge clk);
        mask_wr_en = 1'b1; mask_wr_data = m;
        @(negedge clk);
        mask_wr_en = 1'b0;
    endtask

    // Drive one request, return {valid, accept, bcast, mcast} one cycle later
    task automatic filter(input logic [3:0] mode, input logic [15:0] len,
                          input logic [47:0] dst, output logic [3:0] got);
        @(negedge clk);
        req_valid = 1'b1; req_mode = mode; req_len = len; req_dst = dst;
        @(negedge clk);
        req_valid = 1'b0;
        got = {rsp_valid, rsp_accept, rsp_bcast, rsp_mcast};
    endtask

    task automatic readback(input logic [3:0] p, input logic [1:0] w, output logic [15:0] v);
        @(negedge clk);
        rd_ptr = p; rd_word = w;
        #1;
        v = rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0]  got;
        logic [15:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        in_reset = 1'b1;
        #1;
        check("R1 reset response idle", {12'd0, rsp_valid, rsp_accept, rsp_bcast, rsp_mcast}, 16'h0);
        readback(4'd3, 2'd0, v);
        check("R7 entry zero after reset", v, 16'h0000);

        // R7: stored entry does not match while the mask is still zero
        write_entry(4'd3, STA_A);
        write_entry(4'd5, STA_B);
        filter(4'b0000, 16'd64, STA_A, got);
        check("R7 mask zero rejects", {12'd0, got}, 16'h8);

        // R9: readback word order and gating
        readback(4'd3, 2'd0, v); check("R9 word0", v, 16'h2210);
        readback(4'd3, 2'd1, v); check("R9 word1", v, 16'h4433);
        readback(4'd3, 2'd2, v); check("R9 word2", v, 16'h6655);
        readback(4'd3, 2'd3, v); check("R9 word3 empty", v, 16'h0000);
        readback(4'd5, 2'd1, v); check("R8 entry5 word1", v, 16'h0A09);
        @(negedge clk); in_reset = 1'b0;
        readback(4'd3, 2'd0, v); check("R9 gated outside reset", v, 16'h0000);

        write_mask(16'h0008);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            filter(VECS[i].mode, VECS[i].len, VECS[i].dst, got);
            check($sformatf("R%0d vector %0d", VECS[i].req, i),
                  {12'd0, got}, {12'd0, 1'b1, VECS[i].exp});
        end

        // R1: response lasts exactly one cycle
        filter(4'b0000, 16'd64, STA_A, got);
        @(negedge clk);
        check("R1 single response cycle", {15'd0, rsp_valid}, 16'h0);

        // R1: back-to-back requests each get their own response
        @(negedge clk);
        req_valid = 1'b1; req_mode = 4'b0100; req_len = 16'd64; req_dst = ALL1;
        @(negedge clk);
        req_mode = 4'b0001; req_dst = GRP;
        check("R1 back-to-back first", {12'd0, rsp_valid, rsp_accept, rsp_bcast, rsp_mcast}, 16'hE);
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 back-to-back second", {12'd0, rsp_valid, rsp_accept, rsp_bcast, rsp_mcast}, 16'hD);

        // R6/R8: new mask replaces old one
        write_mask(16'h0020);
        filter(4'b0000, 16'd64, STA_B, got);
        check("R6 entry5 enabled", {12'd0, got}, 16'hC);
        filter(4'b0000, 16'd64, STA_A, got);
        check("R6 entry3 disabled", {12'd0, got}, 16'h8);

        // R8: overwrite entry 5, old address no longer matches
        write_entry(4'd5, STA_U);
        filter(4'b0000, 16'd64, STA_U, got);
        check("R8 overwritten entry matches", {12'd0, got}, 16'hC);
        filter(4'b0000, 16'd64, STA_B, got);
        check("R8 old address gone", {12'd0, got}, 16'h8);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule